// File: doc/BRIEF.md
# Status Register Write-Protection Controller

This block holds the protection bits of a serial memory's status register and decides which writes may proceed. Three bits are stored here: a status-lock bit and a two-bit protection level. The write-enable latch and the busy flag come from neighbouring logic and are only reflected in the status byte. The block answers two questions every cycle: whether a status-register write command may load new protection bits, and whether an array write at a given address lies outside the protected range.

A write-protect pin, active low, is passed through a synchroniser. When the stored lock bit is set and the synchronised pin is low, the register is frozen against every status write. Only raising the pin ends that frozen state. While unfrozen, a status write loads the lock bit and the protection level freely, provided the write-enable latch is set. The protection level selects none, the top quarter, the top half or the whole array. The range is judged from the two most significant address bits.

Top module: `sreg_wp_ctrl`

## Requirements
- R1: After reset the lock bit and both protection-level bits are 0, so with the write-enable latch and busy flag low `status_byte_o` reads 8'h00.
- R2: `status_byte_o` is laid out as bit 7 lock bit, bits 6..4 constant 0, bit 3 level high bit, bit 2 level low bit, bit 1 the current `wel_i`, bit 0 the current `wip_i`. The last two follow their inputs in the same cycle.
- R3: A status write with `wel_i` high and the register not frozen raises `sr_wr_ack_o` in the same cycle. At the next rising edge it loads the lock bit from data bit 7 and the level from data bits 3..2. Data bits 6..4 and 1..0 have no effect.
- R4: A status write with `wel_i` low is ignored: `sr_wr_ack_o` stays low and the stored bits are unchanged.
- R5: `hw_locked_o` is high exactly when the lock bit is 1 and the synchronised pin is 0. While it is high every status write is rejected (no ack, stored bits unchanged).
- R6: Once the synchronised pin is high, the frozen state ends and a status write may clear the lock bit. With the lock bit at 0 a write may set it even while the pin is low.
- R7: A change on `wp_pin_i` reaches `hw_locked_o` after exactly two rising edges of `clk_i`. The synchroniser resets to 0.
- R8: Level 2'b00 protects no address. Level 2'b01 protects addresses whose two top bits are 2'b11. Level 2'b10 protects addresses whose top bit is 1. Level 2'b11 protects every address.
- R9: For an array write request, `arr_wr_grant_o` is high in the same cycle if the address is unprotected, and `arr_wr_reject_o` is high if it is protected. Both are low without a request.
- R10: When a status write and an array write share a cycle, the array write is judged against the protection level held before that status write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_pin_i | input | 1 | Write-protect pin, active low, asynchronous |
| wel_i | input | 1 | Write-enable latch from command logic |
| wip_i | input | 1 | Write-in-progress flag from command logic |
| sr_wr_req_i | input | 1 | Status-register write command, one cycle |
| sr_wr_data_i | input | 8 | Data byte of the status write |
| sr_wr_ack_o | output | 1 | Status write accepted this cycle |
| hw_locked_o | output | 1 | Register frozen by lock bit and pin |
| arr_wr_req_i | input | 1 | Array write request |
| arr_wr_addr_i | input | ADDR_W | Array write address |
| arr_wr_grant_o | output | 1 | Array write allowed |
| arr_wr_reject_o | output | 1 | Array write discarded as protected |
| status_byte_o | output | 8 | Byte returned by a status read |

## Verification
A status write that changes the protection level can arrive in the same cycle as an array write. The bench issues both together and expects the array decision to follow the old level, then repeats the array write one cycle later and expects the new level. A pin transition can also line up with a status write. The randomised phase toggles the pin and status writes together, and the bench's reference model, with its own two-deep pin history, judges whether each ack is correct.

// File: rtl/sreg_wp_pkg.sv
package sreg_wp_pkg;

   localparam int SREG_W   = 8;
   localparam int LOCK_POS = 7;
   localparam int LVL_HI   = 3;
   localparam int LVL_LO   = 2;
   localparam int WEL_POS  = 1;
   localparam int WIP_POS  = 0;

   typedef enum logic [1:0] {
      LVL_NONE    = 2'b00,
      LVL_QUARTER = 2'b01,
      LVL_HALF    = 2'b10,
      LVL_ALL     = 2'b11
   } prot_lvl_e;

   typedef struct packed {
      logic      lock;
      prot_lvl_e lvl;
   } prot_bits_t;

   function automatic logic [SREG_W-1:0] pack_status(prot_bits_t b, logic wel, logic wip);
      logic [SREG_W-1:0] s;
      s           = '0;
      s[LOCK_POS] = b.lock;
      s[LVL_HI]   = b.lvl[1];
      s[LVL_LO]   = b.lvl[0];
      s[WEL_POS]  = wel;
      s[WIP_POS]  = wip;
      return s;
   endfunction

endpackage

// File: rtl/wp_pin_sync.sv
module wp_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wp_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= RST_VAL;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= RST_VAL;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/prot_range_dec.sv
module prot_range_dec
   import sreg_wp_pkg::*;
(
   input  prot_lvl_e  lvl_i,
   input  logic [1:0] top_i,
   output logic       hit_o
);

   always_comb begin
      unique case (lvl_i)
         LVL_NONE:    hit_o = 1'b0;
         LVL_QUARTER: hit_o = (top_i == 2'b11);
         LVL_HALF:    hit_o = top_i[1];
         default:     hit_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/prot_bits_store.sv
module prot_bits_store
   import sreg_wp_pkg::*;
#(
   parameter prot_bits_t RST_BITS = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_req_i,
   input  logic [SREG_W-1:0] wr_data_i,
   input  logic              wel_i,
   input  logic              frozen_i,
   output logic              ack_o,
   output prot_bits_t        bits_o
);

   prot_bits_t bits_q;
   prot_bits_t bits_new;
   logic       unused_data;

   assign bits_new.lock = wr_data_i[LOCK_POS];
   assign bits_new.lvl  = prot_lvl_e'({wr_data_i[LVL_HI], wr_data_i[LVL_LO]});
   assign unused_data   = ^{wr_data_i[6:4], wr_data_i[WEL_POS], wr_data_i[WIP_POS]};

   assign ack_o = wr_req_i & wel_i & ~frozen_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    bits_q <= RST_BITS;
      else if (ack_o) bits_q <= bits_new;
   end

   assign bits_o = bits_q;

   // R4
   no_wel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && !wel_i) |=> $stable(bits_q));

   // R5
   frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && frozen_i) |=> $stable(bits_q));

   // R3
   wrsr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && wel_i && !frozen_i) |=>
         (bits_q == $past({wr_data_i[LOCK_POS], wr_data_i[LVL_HI], wr_data_i[LVL_LO]})));

endmodule

// File: rtl/sreg_wp_ctrl.sv
module sreg_wp_ctrl
   import sreg_wp_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wp_pin_i,
   input  logic              wel_i,
   input  logic              wip_i,
   input  logic              sr_wr_req_i,
   input  logic [SREG_W-1:0] sr_wr_data_i,
   output logic              sr_wr_ack_o,
   output logic              hw_locked_o,
   input  logic              arr_wr_req_i,
   input  logic [ADDR_W-1:0] arr_wr_addr_i,
   output logic              arr_wr_grant_o,
   output logic              arr_wr_reject_o,
   output logic [SREG_W-1:0] status_byte_o
);

   localparam int TOP_HI = ADDR_W - 1;
   localparam int TOP_LO = ADDR_W - 2;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("sreg_wp_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   logic       pin_sync;
   logic       frozen;
   logic       in_range;
   prot_bits_t bits;
   logic       unused_addr;

   wp_pin_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (wp_pin_i),
      .q_o    (pin_sync)
   );

   assign frozen = bits.lock & ~pin_sync;

   prot_bits_store u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_req_i  (sr_wr_req_i),
      .wr_data_i (sr_wr_data_i),
      .wel_i     (wel_i),
      .frozen_i  (frozen),
      .ack_o     (sr_wr_ack_o),
      .bits_o    (bits)
   );

   prot_range_dec u_dec (
      .lvl_i (bits.lvl),
      .top_i (arr_wr_addr_i[TOP_HI:TOP_LO]),
      .hit_o (in_range)
   );

   generate
      if (ADDR_W > 2) begin : g_low_addr
         assign unused_addr = ^arr_wr_addr_i[TOP_LO-1:0];
      end else begin : g_no_low_addr
         assign unused_addr = 1'b0;
      end
   endgenerate

   assign hw_locked_o     = frozen;
   assign arr_wr_grant_o  = arr_wr_req_i & ~in_range;
   assign arr_wr_reject_o = arr_wr_req_i & in_range;
   assign status_byte_o   = pack_status(bits, wel_i, wip_i);

   // R8
   full_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arr_wr_req_i && status_byte_o[LVL_HI] && status_byte_o[LVL_LO]) |-> arr_wr_reject_o);

   // R8
   none_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arr_wr_req_i && !status_byte_o[LVL_HI] && !status_byte_o[LVL_LO]) |-> arr_wr_grant_o);

   // R5
   locked_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_locked_o |-> !sr_wr_ack_o);

endmodule

// File: tb/sreg_wp_ctrl_tb_top.sv
module sreg_wp_ctrl_tb_top;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin = 1'b1;
   logic          wel = 1'b0;
   logic          wip = 1'b0;
   logic          sr_req = 1'b0;
   logic [7:0]    sr_data = 8'h00;
   logic          ar_req = 1'b0;
   logic [AW-1:0] ar_addr = '0;
   logic          ack, locked, grant, reject;
   logic [7:0]    status;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   sreg_wp_ctrl #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .wp_pin_i        (pin),
      .wel_i           (wel),
      .wip_i           (wip),
      .sr_wr_req_i     (sr_req),
      .sr_wr_data_i    (sr_data),
      .sr_wr_ack_o     (ack),
      .hw_locked_o     (locked),
      .arr_wr_req_i    (ar_req),
      .arr_wr_addr_i   (ar_addr),
      .arr_wr_grant_o  (grant),
      .arr_wr_reject_o (reject),
      .status_byte_o   (status)
   );

   // reference model
   bit m_lock;
   bit [1:0] m_lvl;
   bit pin_hist[$];

   function automatic bit m_pin_sync();
      return (pin_hist.size() >= 2) ? pin_hist[1] : 1'b0;
   endfunction

   function automatic bit m_frozen();
      return m_lock && !m_pin_sync();
   endfunction

   function automatic bit m_protected(input logic [AW-1:0] a);
      int top = int'(a) / (1 << (AW - 2));
      case (m_lvl)
         2'd0: return 1'b0;
         2'd1: return top == 3;
         2'd2: return top >= 2;
         default: return 1'b1;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lock = 0;
         m_lvl  = 0;
         pin_hist.delete();
      end else begin
         if (sr_req && wel && !m_frozen()) begin
            m_lock = sr_data[7];
            m_lvl  = sr_data[3:2];
         end
         pin_hist.push_front(pin);
         if (pin_hist.size() > 4) void'(pin_hist.pop_back());
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 status", 16'(status), 16'({m_lock, 3'b000, m_lvl, wel, wip}));
         chk("R7 hw_locked", 16'(locked), 16'(m_frozen()));
         chk("R3 ack", 16'(ack), 16'(sr_req && wel && !m_frozen()));
         chk("R9 grant", 16'(grant), 16'(ar_req && !m_protected(ar_addr)));
         chk("R9 reject", 16'(reject), 16'(ar_req && m_protected(ar_addr)));
      end
   end

   task automatic put(input logic s, input logic [7:0] d, input logic w,
                      input logic a, input logic [AW-1:0] ad);
      @(posedge clk); #1;
      sr_req = s; sr_data = d; wel = w; ar_req = a; ar_addr = ad;
      @(negedge clk);
   endtask

   task automatic idle();
      put(1'b0, 8'h00, 1'b0, 1'b0, '0);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle();
      chk("R1 status after reset", 16'(status), 16'h00);
      chk("R1 hw_locked after reset", 16'(locked), 16'h0);

      put(1'b1, 8'h8C, 1'b0, 1'b0, '0);
      chk("R4 ack without wel", 16'(ack), 16'h0);
      idle();
      chk("R4 bits unchanged", 16'(status), 16'h00);

      put(1'b1, 8'hFF, 1'b1, 1'b0, '0);
      chk("R3 ack", 16'(ack), 16'h1);
      idle();
      chk("R3 load ignores bits 6..4 1..0", 16'(status), 16'h8C);
      put(1'b0, 8'h00, 1'b1, 1'b0, '0); wip = 1'b1;
      #1 chk("R2 wel wip reflected", 16'(status), 16'h8F);
      put(1'b0, 8'h00, 1'b0, 1'b1, 16'h0000); wip = 1'b0;
      chk("R8 all protects 0000", 16'(reject), 16'h1);

      pin = 1'b0;
      idle();
      chk("R7 one edge no lock", 16'(locked), 16'h0);
      idle();
      chk("R7 two edges lock", 16'(locked), 16'h1);
      put(1'b1, 8'h00, 1'b1, 1'b0, '0);
      chk("R5 frozen rejects", 16'(ack), 16'h0);
      idle();
      chk("R5 bits held", 16'(status), 16'h8C);

      pin = 1'b1;
      idle();
      chk("R7 still locked one edge", 16'(locked), 16'h1);
      idle();
      chk("R6 pin high unlocks", 16'(locked), 16'h0);
      put(1'b1, 8'h04, 1'b1, 1'b0, '0);
      chk("R6 clear lock accepted", 16'(ack), 16'h1);
      put(1'b0, 8'h00, 1'b0, 1'b1, 16'hC000);
      chk("R8 quarter C000", 16'(reject), 16'h1);
      put(1'b0, 8'h00, 1'b0, 1'b1, 16'hBFFF);
      chk("R8 quarter BFFF", 16'(grant), 16'h1);

      put(1'b1, 8'h08, 1'b1, 1'b1, 16'h8000);
      chk("R10 old level judges", 16'(grant), 16'h1);
      put(1'b0, 8'h00, 1'b0, 1'b1, 16'h8000);
      chk("R10 new level next cycle", 16'(reject), 16'h1);
      put(1'b0, 8'h00, 1'b0, 1'b1, 16'h7FFF);
      chk("R8 half 7FFF", 16'(grant), 16'h1);

      pin = 1'b0;
      idle(); idle();
      chk("R5 pin low without lock bit", 16'(locked), 16'h0);
      put(1'b1, 8'h80, 1'b1, 1'b0, '0);
      chk("R6 set lock with pin low", 16'(ack), 16'h1);
      idle();
      chk("R5 lock now active", 16'(locked), 16'h1);
      chk("R5 status", 16'(status), 16'h80);

      pin = 1'b1;
      idle(); idle();
      put(1'b1, 8'h00, 1'b1, 1'b0, '0);
      chk("R6 unlock write", 16'(ack), 16'h1);
      put(1'b0, 8'h00, 1'b0, 1'b1, 16'hFFFF);
      chk("R8 none FFFF", 16'(grant), 16'h1);
      chk("R9 no reject", 16'(reject), 16'h0);
      idle();
      chk("R9 idle no grant", 16'(grant | reject), 16'h0);

      for (int i = 0; i < 600; i++) begin
         if (($urandom % 8) == 0) pin = ~pin;
         wip = 1'($urandom);
         put(($urandom % 3) == 0, 8'($urandom), ($urandom % 4) != 0,
             1'($urandom), AW'($urandom));
      end

      idle();
      done = 1;
      summary();
      $finish;
   end

endmodule